// File: doc/BRIEF.md
# Smart card contact power sequencer

This block takes one contact smart card through a cold reset and back down. On an accepted start it applies the card supply first. After a short settling span it starts the card clock. It releases the I/O line at a fixed card-clock count and raises the card reset line after a longer count. It then listens for the first falling edge of the card's answer on I/O. An answer that comes too soon raises a sticky early flag. An answer that never comes raises a sticky mute flag and powers the card down.

All timing during activation is counted in card clock cycles, using a one-cycle `tick` pulse per card clock. Power-down steps are counted in system clocks. A stop request, card removal or a missed answer window starts the power-down. Power-down changes the lines one at a time in a fixed order, each held for a programmable span. The block carries no data stream, so every pin is a plain level or pulse with no handshake.

Top module: `card_power_seq`

## Requirements
- R1: After reset, `card_rst`, `vcc_on`, `vpp_on`, `clk_run`, `active`, `mute` and `early` are 0 and `io_hold_low` is 1.
- R2: A `start_req` seen in the idle phase while `card_present` is 1 sets `vcc_on` at that clock edge, with `card_rst` low and `vpp_on` low, and clears `mute` and `early`. `clk_run` rises STEP_CLKS clocks later.
- R3: `io_hold_low` falls in the clock after IO_REL_TICKS ticks have been counted since `clk_run` rose. IO_REL_TICKS is at most 200 and below RST_LOW_TICKS.
- R4: `card_rst` rises in the clock after RST_LOW_TICKS ticks have been counted since `clk_run` rose. It is only ever high while `clk_run` is high.
- R5: If a falling edge on `io_in` (1 in one clock, 0 in the next) arrives while `card_rst` is high and fewer than ATR_MIN_TICKS ticks have passed since it rose, `early` is set and the card stays powered.
- R6: If such a falling edge arrives with at least ATR_MIN_TICKS ticks counted, the card stays powered and no flag is set.
- R7: If ATR_MAX_TICKS ticks pass after `card_rst` rose with no falling edge, `mute` is set and power-down starts at the same edge.
- R8: Power-down drops `card_rst` at entry. Then, each STEP_CLKS clocks apart, it drops `clk_run`, then `vpp_on`, then raises `io_hold_low`, then drops `vcc_on`. The block is idle STEP_CLKS clocks after that. No two of these five lines ever change in the same clock.
- R9: `stop_req` high, or `card_present` low, starts power-down from any phase between supply-on and the answered state.
- R10: `active` is high exactly while the card supply is applied.
- R11: `start_req` has no effect in any phase other than idle, or while `card_present` is 0.
- R12: `mute` and `early` keep their value through power-down and idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse per card clock cycle |
| start_req | input | 1 | Request a cold activation |
| stop_req | input | 1 | Request power-down |
| card_present | input | 1 | 1 while a card is seated |
| io_in | input | 1 | Sampled card I/O line |
| card_rst | output | 1 | Card reset line level |
| vcc_on | output | 1 | Card supply enable |
| vpp_on | output | 1 | Programming supply enable (held idle) |
| clk_run | output | 1 | Card clock gate |
| io_hold_low | output | 1 | 1 drives card I/O low; 0 releases it to receive |
| active | output | 1 | Card supply applied |
| mute | output | 1 | Answer window expired |
| early | output | 1 | Answer began before the window opened |

## Verification
The bench aims at the answer-window edges. It checks an answer well inside the window, an answer after only a few ticks, and no answer at all. A design with an off-by-one window or a wrong comparison would set `early` or `mute` in the wrong run, or keep a silent card powered. It stops activation in mid-clocking to show that an abort obeys the power-down order rather than cutting the supply at once. It leaves the flags standing across power-down to catch flags cleared too soon. It issues starts while busy or with no card, which a loose guard would act on by restarting the supply sequence.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_POWER,
    PH_CLOCK,
    PH_WAIT,
    PH_RUN,
    PH_DOWN
  } phase_t;

  typedef enum logic [2:0] {
    DS_RST,
    DS_CLK,
    DS_VPP,
    DS_IO,
    DS_VCC
  } down_step_t;

  typedef struct packed {
    logic rst;
    logic vcc;
    logic vpp;
    logic clk;
    logic io_low;
  } lines_t;

endpackage

// File: rtl/cps_span_timer.sv
module cps_span_timer #(
  parameter int STEP_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic done
);
  localparam int SPW = $clog2(STEP_CLKS + 1);
  localparam logic [SPW-1:0] LAST = SPW'(STEP_CLKS - 1);

  logic [SPW-1:0] cnt_q;

  assign done = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end

  a_r8_span_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/cps_tick_window.sv
module cps_tick_window #(
  parameter int CNT_MAX = 40000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          tick,
  output logic [$clog2(CNT_MAX+1)-1:0]  count
);
  localparam int TW = $clog2(CNT_MAX + 1);
  localparam logic [TW-1:0] TOP = TW'(CNT_MAX);

  logic [TW-1:0] cnt_q;

  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clear)                 cnt_q <= '0;
    else if (tick && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  a_r7_window_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clear) |=> cnt_q == TOP);

endmodule

// File: rtl/cps_fall_detect.sv
module cps_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic fall
);
  logic prev_q;

  assign fall = prev_q & ~line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line;
  end

endmodule

// File: rtl/card_power_seq.sv
module card_power_seq #(
  parameter int STEP_CLKS     = 16,
  parameter int IO_REL_TICKS  = 180,
  parameter int RST_LOW_TICKS = 400,
  parameter int ATR_MIN_TICKS = 400,
  parameter int ATR_MAX_TICKS = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_req,
  input  logic stop_req,
  input  logic card_present,
  input  logic io_in,
  output logic card_rst,
  output logic vcc_on,
  output logic vpp_on,
  output logic clk_run,
  output logic io_hold_low,
  output logic active,
  output logic mute,
  output logic early
);
  import cps_pkg::*;

  localparam int CNT_MAX = (ATR_MAX_TICKS > RST_LOW_TICKS) ? ATR_MAX_TICKS : RST_LOW_TICKS;
  localparam int TW      = $clog2(CNT_MAX + 1);
  localparam logic [TW-1:0] IO_AT   = TW'(IO_REL_TICKS);
  localparam logic [TW-1:0] RST_AT  = TW'(RST_LOW_TICKS);
  localparam logic [TW-1:0] MIN_AT  = TW'(ATR_MIN_TICKS);
  localparam logic [TW-1:0] MAX_AT  = TW'(ATR_MAX_TICKS);

  phase_t     ph_q, ph_d;
  down_step_t step_q, step_d;
  lines_t     ln_q, ln_d;
  logic       mute_q, mute_d, early_q, early_d;
  logic       span_clr, span_done, win_clr, io_fall, abort, enter_down;
  logic [TW-1:0] win_cnt;

  cps_span_timer #(.STEP_CLKS(STEP_CLKS)) u_span (
    .clk(clk), .rst_n(rst_n), .clear(span_clr), .done(span_done)
  );

  cps_tick_window #(.CNT_MAX(CNT_MAX)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(win_clr), .tick(tick), .count(win_cnt)
  );

  cps_fall_detect u_fall (
    .clk(clk), .rst_n(rst_n), .line(io_in), .fall(io_fall)
  );

  assign abort = stop_req | ~card_present;

  always_comb begin
    ph_d       = ph_q;
    step_d     = step_q;
    ln_d       = ln_q;
    mute_d     = mute_q;
    early_d    = early_q;
    span_clr   = 1'b0;
    win_clr    = 1'b0;
    enter_down = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_req && card_present) begin
          ph_d     = PH_POWER;
          ln_d.vcc = 1'b1;
          mute_d   = 1'b0;
          early_d  = 1'b0;
          span_clr = 1'b1;
        end
      end
      PH_POWER: begin
        if (abort) enter_down = 1'b1;
        else if (span_done) begin
          ph_d     = PH_CLOCK;
          ln_d.clk = 1'b1;
          win_clr  = 1'b1;
        end
      end
      PH_CLOCK: begin
        if (abort) enter_down = 1'b1;
        else if (win_cnt == RST_AT) begin
          ph_d     = PH_WAIT;
          ln_d.rst = 1'b1;
          win_clr  = 1'b1;
        end else if (win_cnt == IO_AT) begin
          ln_d.io_low = 1'b0;
        end
      end
      PH_WAIT: begin
        if (abort) enter_down = 1'b1;
        else if (io_fall) begin
          ph_d = PH_RUN;
          if (win_cnt < MIN_AT) early_d = 1'b1;
        end else if (win_cnt == MAX_AT) begin
          mute_d     = 1'b1;
          enter_down = 1'b1;
        end
      end
      PH_RUN: begin
        if (abort) enter_down = 1'b1;
      end
      PH_DOWN: begin
        if (span_done) begin
          span_clr = 1'b1;
          unique case (step_q)
            DS_RST: begin step_d = DS_CLK; ln_d.clk    = 1'b0; end
            DS_CLK: begin step_d = DS_VPP; ln_d.vpp    = 1'b0; end
            DS_VPP: begin step_d = DS_IO;  ln_d.io_low = 1'b1; end
            DS_IO:  begin step_d = DS_VCC; ln_d.vcc    = 1'b0; end
            DS_VCC: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
          endcase
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (enter_down) begin
      ph_d     = PH_DOWN;
      step_d   = DS_RST;
      ln_d.rst = 1'b0;
      span_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      step_q  <= DS_RST;
      ln_q    <= '{rst: 1'b0, vcc: 1'b0, vpp: 1'b0, clk: 1'b0, io_low: 1'b1};
      mute_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      step_q  <= step_d;
      ln_q    <= ln_d;
      mute_q  <= mute_d;
      early_q <= early_d;
    end
  end

  assign card_rst    = ln_q.rst;
  assign vcc_on      = ln_q.vcc;
  assign vpp_on      = ln_q.vpp;
  assign clk_run     = ln_q.clk;
  assign io_hold_low = ln_q.io_low;
  assign active      = ln_q.vcc;
  assign mute        = mute_q;
  assign early       = early_q;

  // R8: lines move one at a time
  a_r8_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ln_q ^ $past(ln_q)) <= 1);

  a_r4_rst_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> clk_run);

  a_r2_supply_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_run) |-> vcc_on);

  a_r8_supply_off_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_on) |-> (!clk_run && !card_rst && io_hold_low && !vpp_on));

  a_r7_mute_drops_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> !card_rst);

  a_r12_flags_hold_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!vcc_on) && !vcc_on) |-> ($stable(mute) && $stable(early)));

  a_r3_io_free_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> !io_hold_low);

endmodule

// File: tb/card_power_seq_test.sv
module card_power_seq_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int STEP = 3;
  localparam int IOR  = 20;
  localparam int RSL  = 40;
  localparam int AMIN = 40;
  localparam int AMAX = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, card_present = 1'b0;
  logic card_io = 1'b1;
  logic io_in;
  logic card_rst, vcc_on, vpp_on, clk_run, io_hold_low, active, mute, early;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tdiv = 0;

  // reference model state
  int m_ph, m_hold, m_ticks, m_step;
  bit m_rst, m_vcc, m_vpp, m_clk, m_iol, m_mute, m_early, m_prev;
  bit m_fall, m_abort, m_down;

  always #2.5 clk = ~clk;

  assign io_in = io_hold_low ? 1'b0 : card_io;

  card_power_seq #(
    .STEP_CLKS(STEP), .IO_REL_TICKS(IOR), .RST_LOW_TICKS(RSL),
    .ATR_MIN_TICKS(AMIN), .ATR_MAX_TICKS(AMAX)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
    .stop_req(stop_req), .card_present(card_present), .io_in(io_in),
    .card_rst(card_rst), .vcc_on(vcc_on), .vpp_on(vpp_on), .clk_run(clk_run),
    .io_hold_low(io_hold_low), .active(active), .mute(mute), .early(early)
  );

  task automatic chk(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst = 0; m_vcc = 0; m_vpp = 0; m_clk = 0; m_iol = 1;
      m_mute = 0; m_early = 0; m_ph = 0; m_hold = 0; m_ticks = 0; m_step = 0; m_prev = 1;
    end else begin
      m_fall  = m_prev && !io_in;
      m_prev  = io_in;
      m_abort = stop_req || !card_present;
      m_down  = 0;
      case (m_ph)
        0: if (start_req && card_present) begin
             m_ph = 1; m_vcc = 1; m_mute = 0; m_early = 0; m_hold = 0;
           end
        1: if (m_abort) m_down = 1;
           else if (m_hold == STEP - 1) begin m_ph = 2; m_clk = 1; m_ticks = 0; end
           else m_hold++;
        2: if (m_abort) m_down = 1;
           else if (m_ticks == RSL) begin m_rst = 1; m_ph = 3; m_ticks = 0; end
           else begin
             if (m_ticks == IOR) m_iol = 0;
             if (tick) m_ticks++;
           end
        3: if (m_abort) m_down = 1;
           else if (m_fall) begin if (m_ticks < AMIN) m_early = 1; m_ph = 4; end
           else if (m_ticks == AMAX) begin m_mute = 1; m_down = 1; end
           else if (tick) m_ticks++;
        4: if (m_abort) m_down = 1;
        5: if (m_hold == STEP - 1) begin
             m_hold = 0;
             if (m_step == 4) m_ph = 0;
             else begin
               m_step++;
               case (m_step)
                 1: m_clk = 0;
                 2: m_vpp = 0;
                 3: m_iol = 1;
                 default: m_vcc = 0;
               endcase
             end
           end else m_hold++;
        default: m_ph = 0;
      endcase
      if (m_down) begin m_ph = 5; m_step = 0; m_hold = 0; m_rst = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(card_rst,    m_rst,   "R4 card_rst");
      chk(vcc_on,      m_vcc,   "R2 vcc_on");
      chk(vpp_on,      m_vpp,   "R8 vpp_on");
      chk(clk_run,     m_clk,   "R8 clk_run");
      chk(io_hold_low, m_iol,   "R3 io_hold_low");
      chk(active,      m_vcc,   "R10 active");
      chk(mute,        m_mute,  "R7 mute");
      chk(early,       m_early, "R5 early");
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
  endtask

  task automatic wait_idle();
    while (vcc_on) @(negedge clk);
    repeat (STEP + 2) @(negedge clk);
  endtask

  task automatic answer_after(input int nticks);
    while (!card_rst) @(negedge clk);
    repeat (4 * nticks) @(negedge clk);
    card_io = 0;
    repeat (6) @(negedge clk);
    card_io = 1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(card_rst, 0, "R1 reset card_rst");
    chk(vcc_on, 0, "R1 reset vcc_on");
    chk(clk_run, 0, "R1 reset clk_run");
    chk(io_hold_low, 1, "R1 reset io_hold_low");
    chk(mute | early | active, 0, "R1 reset flags");

    // start with no card: ignored
    pulse_start();
    repeat (5) @(negedge clk);
    chk(vcc_on, 0, "R11 start without card");

    // normal activation, answer inside the window
    card_present = 1;
    pulse_start();
    while (!card_rst) @(negedge clk);
    chk(io_hold_low, 0, "R3 io released before reset rise");
    chk(clk_run, 1, "R4 clock running at reset rise");
    answer_after(100);
    repeat (20) @(negedge clk);
    chk(vcc_on, 1, "R6 powered after in-window answer");
    chk(mute | early, 0, "R6 no flag in window");
    pulse_start();
    repeat (5) @(negedge clk);
    chk(card_rst, 1, "R11 start ignored while active");
    stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk(card_rst, 0, "R8 reset drops first");
    chk(clk_run, 1, "R8 clock still running at step one");
    wait_idle();
    chk(io_hold_low, 1, "R8 io held low when idle");

    // early answer, then card removal
    pulse_start();
    answer_after(10);
    repeat (10) @(negedge clk);
    chk(early, 1, "R5 early answer flagged");
    chk(vcc_on, 1, "R5 card stays powered");
    card_present = 0;
    @(negedge clk);
    chk(card_rst, 0, "R9 removal starts power-down");
    card_present = 1;
    wait_idle();
    chk(early, 1, "R12 early kept after power-down");
    pulse_start();
    chk(early, 0, "R12 early cleared by new start");

    // silent card
    while (!mute) @(negedge clk);
    chk(card_rst, 0, "R7 reset low on timeout");
    wait_idle();
    chk(mute, 1, "R12 mute kept while idle");

    // stop in the middle of clocking
    pulse_start();
    while (!clk_run) @(negedge clk);
    repeat (20) @(negedge clk);
    stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk(clk_run, 1, "R9 clock held during first step");
    repeat (STEP - 1) @(negedge clk);
    chk(clk_run, 1, "R8 clock held for step span");
    @(negedge clk);
    chk(clk_run, 0, "R8 clock stops after step span");
    chk(vcc_on, 1, "R8 supply still on");
    wait_idle();
    chk(active, 0, "R10 inactive when idle");

    finish_run();
  end

endmodule